// File: doc/BRIEF.md
# Dual-ALU Out-of-Order Integer Issue Queue

This block holds decoded integer instructions until their source operands are available. It then hands them to two integer execution units. Each entry records an operation class, two physical source tags with a ready flag each, and a destination tag. Up to four new instructions arrive per cycle and are placed into free slots. The slots carry no program order. Result tags broadcast by the execution side wake up waiting operands.

Every cycle the queue selects at most one instruction for each unit. The operation class steers the choice:
- Branch and shift operations may only go to the first unit.
- Multiply and divide operations may only go to the second unit.
- Every other class may go to either unit.

An entry is released on the cycle it issues. A flush input empties the whole queue at once.

The issue outputs depend combinationally on the stored entries, so an eligible entry is offered in the same cycle that it becomes eligible. Writes, wakeups, releases and flushes all take effect at the clock edge.

Top module: `int_issue_queue`

## Requirements
- R1: While reset is held, and on the first cycle after it, both issue valids are low and `wr_accept` is high.
- R2: Write port k places its instruction into the k-th lowest-indexed free slot, counting k from 0. This only happens when `in_valid[k]` is high and `wr_accept` is high. Writes offered while `wr_accept` is low are dropped.
- R3: `wr_accept` is high exactly when at least four slots are free. The free count is taken before the current cycle's issues and writes.
- R4: An entry is eligible when both of its source ready flags are set, regardless of when it was written. Among eligible candidates for a unit, the lowest index wins.
- R5: Class codes are 0 plain, 1 branch, 2 shift, 3 multiply and 4 divide. Codes 5 to 7 are treated as plain. Classes 1 and 2 never issue on unit 2.
- R6: Classes 3 and 4 never issue on unit 1.
- R7: Unit 1 is chosen first. Unit 2 then takes the lowest eligible entry that is allowed on it and was not taken by unit 1.
- R8: While `alu2_busy` is high, nothing issues on unit 2.
- R9: A valid broadcast tag sets the ready flag of every stored source that carries that tag. A new instruction whose source matches a broadcast in its write cycle is stored as ready.
- R10: `flush` empties every slot at the next edge, and writes offered in that cycle are dropped.
- R11: An entry is released at the edge that ends its issue cycle, and it never issues twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the queue |
| in_valid | input | PORTS | Per-port write request |
| in_cls | input | PORTS x CLS_W | Operation class per port |
| in_src0 | input | PORTS x TAG_W | First source tag per port |
| in_rdy0 | input | PORTS | First source already available |
| in_src1 | input | PORTS x TAG_W | Second source tag per port |
| in_rdy1 | input | PORTS | Second source already available |
| in_dst | input | PORTS x TAG_W | Destination tag per port |
| wr_accept | output | 1 | Queue can take a full group of writes |
| bc_valid | input | NBC | Result broadcast valid per lane |
| bc_tag | input | NBC x TAG_W | Broadcast result tags |
| alu2_busy | input | 1 | Unit 2 is occupied by a long operation |
| iss1_valid | output | 1 | Instruction issued to unit 1 |
| iss1_cls | output | CLS_W | Its class |
| iss1_src0 | output | TAG_W | Its first source tag |
| iss1_src1 | output | TAG_W | Its second source tag |
| iss1_dst | output | TAG_W | Its destination tag |
| iss2_valid | output | 1 | Instruction issued to unit 2 |
| iss2_cls | output | CLS_W | Its class |
| iss2_src0 | output | TAG_W | Its first source tag |
| iss2_src1 | output | TAG_W | Its second source tag |
| iss2_dst | output | TAG_W | Its destination tag |

## Verification
The bench builds the queue with its defaults: 16 slots, four write ports, 6-bit tags and two broadcast lanes. With these values, four full write groups fill the queue so that the accept signal drops while writes are still being offered. Source tags are drawn from a pool of eight values, so the two broadcast lanes frequently hit many entries at once, including entries written in the same cycle. The random phases mix all eight class codes with the unit-2 busy flag and flushes. This puts both the class steering and the lowest-index tie-breaking under load.

// File: rtl/iq_pkg.sv
package iq_pkg;

    localparam int CLS_W = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_PLAIN  = 3'd0,
        CLS_BRANCH = 3'd1,
        CLS_SHIFT  = 3'd2,
        CLS_MUL    = 3'd3,
        CLS_DIV    = 3'd4
    } iq_cls_e;

    // Classes restricted to unit 1
    function automatic logic unit1_only(input logic [CLS_W-1:0] c);
        return (c == CLS_BRANCH) || (c == CLS_SHIFT);
    endfunction

    // Classes restricted to unit 2
    function automatic logic unit2_only(input logic [CLS_W-1:0] c);
        return (c == CLS_MUL) || (c == CLS_DIV);
    endfunction

endpackage

// File: rtl/iq_tag_match.sv
module iq_tag_match #(
    parameter int TAG_W = 6,
    parameter int NBC   = 2
) (
    input  logic [TAG_W-1:0]          tag,
    input  logic [NBC-1:0]            bc_v,
    input  logic [NBC-1:0][TAG_W-1:0] bc_tag,
    output logic                      hit
);
    always_comb begin
        hit = 1'b0;
        for (int b = 0; b < NBC; b++) begin
            if (bc_v[b] && (bc_tag[b] == tag)) hit = 1'b1;
        end
    end
endmodule

// File: rtl/iq_alloc.sv
module iq_alloc #(
    parameter int DEPTH = 16,
    parameter int PORTS = 4,
    localparam int PW   = (PORTS > 1) ? $clog2(PORTS) : 1
) (
    input  logic [DEPTH-1:0]          free,
    output logic [DEPTH-1:0]          slot_hit,
    output logic [DEPTH-1:0][PW-1:0]  slot_port,
    output logic                      enough
);
    int rank;
    int nfree;

    always_comb begin
        rank  = 0;
        nfree = 0;
        for (int i = 0; i < DEPTH; i++) begin
            slot_hit[i]  = 1'b0;
            slot_port[i] = '0;
            if (free[i]) begin
                nfree = nfree + 1;
                if (rank < PORTS) begin
                    slot_hit[i]  = 1'b1;
                    slot_port[i] = PW'(rank);
                    rank = rank + 1;
                end
            end
        end
        enough = (nfree >= PORTS);
    end
endmodule

// File: rtl/iq_select.sv
module iq_select #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/int_issue_queue.sv
module int_issue_queue
    import iq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PORTS = 4,
    parameter int TAG_W = 6,
    parameter int NBC   = 2,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PW    = (PORTS > 1) ? $clog2(PORTS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic [PORTS-1:0]              in_valid,
    input  logic [PORTS-1:0][CLS_W-1:0]   in_cls,
    input  logic [PORTS-1:0][TAG_W-1:0]   in_src0,
    input  logic [PORTS-1:0]              in_rdy0,
    input  logic [PORTS-1:0][TAG_W-1:0]   in_src1,
    input  logic [PORTS-1:0]              in_rdy1,
    input  logic [PORTS-1:0][TAG_W-1:0]   in_dst,
    output logic                          wr_accept,
    input  logic [NBC-1:0]                bc_valid,
    input  logic [NBC-1:0][TAG_W-1:0]     bc_tag,
    input  logic                          alu2_busy,
    output logic                          iss1_valid,
    output logic [CLS_W-1:0]              iss1_cls,
    output logic [TAG_W-1:0]              iss1_src0,
    output logic [TAG_W-1:0]              iss1_src1,
    output logic [TAG_W-1:0]              iss1_dst,
    output logic                          iss2_valid,
    output logic [CLS_W-1:0]              iss2_cls,
    output logic [TAG_W-1:0]              iss2_src0,
    output logic [TAG_W-1:0]              iss2_src1,
    output logic [TAG_W-1:0]              iss2_dst
);

    // Entry storage
    logic [DEPTH-1:0]             valid_q;
    logic [DEPTH-1:0]             rdy0_q;
    logic [DEPTH-1:0]             rdy1_q;
    logic [DEPTH-1:0][CLS_W-1:0]  cls_q;
    logic [DEPTH-1:0][TAG_W-1:0]  src0_q;
    logic [DEPTH-1:0][TAG_W-1:0]  src1_q;
    logic [DEPTH-1:0][TAG_W-1:0]  dst_q;

    // Wakeup
    logic [DEPTH-1:0] wake0, wake1;
    logic [PORTS-1:0] nwake0, nwake1;

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry_wake
        iq_tag_match #(.TAG_W(TAG_W), .NBC(NBC)) u_m0 (
            .tag(src0_q[i]), .bc_v(bc_valid), .bc_tag(bc_tag), .hit(wake0[i])
        );
        iq_tag_match #(.TAG_W(TAG_W), .NBC(NBC)) u_m1 (
            .tag(src1_q[i]), .bc_v(bc_valid), .bc_tag(bc_tag), .hit(wake1[i])
        );
    end

    for (genvar k = 0; k < PORTS; k++) begin : g_port_wake
        iq_tag_match #(.TAG_W(TAG_W), .NBC(NBC)) u_n0 (
            .tag(in_src0[k]), .bc_v(bc_valid), .bc_tag(bc_tag), .hit(nwake0[k])
        );
        iq_tag_match #(.TAG_W(TAG_W), .NBC(NBC)) u_n1 (
            .tag(in_src1[k]), .bc_v(bc_valid), .bc_tag(bc_tag), .hit(nwake1[k])
        );
    end

    // Selection
    logic [DEPTH-1:0] eligible, u1_req, u2_req, u2_req_m;
    logic             found1, found2;
    logic [IDX_W-1:0] pick1, pick2;

    always_comb begin
        eligible = valid_q & rdy0_q & rdy1_q;
        for (int i = 0; i < DEPTH; i++) begin
            u1_req[i] = eligible[i] && !unit2_only(cls_q[i]);
            u2_req[i] = eligible[i] && !unit1_only(cls_q[i]) && !alu2_busy;
        end
    end

    iq_select #(.DEPTH(DEPTH)) u_sel1 (
        .req(u1_req), .found(found1), .idx(pick1)
    );

    always_comb begin
        u2_req_m = u2_req;
        if (found1) u2_req_m[pick1] = 1'b0;
    end

    iq_select #(.DEPTH(DEPTH)) u_sel2 (
        .req(u2_req_m), .found(found2), .idx(pick2)
    );

    assign iss1_valid = found1;
    assign iss1_cls   = cls_q[pick1];
    assign iss1_src0  = src0_q[pick1];
    assign iss1_src1  = src1_q[pick1];
    assign iss1_dst   = dst_q[pick1];
    assign iss2_valid = found2;
    assign iss2_cls   = cls_q[pick2];
    assign iss2_src0  = src0_q[pick2];
    assign iss2_src1  = src1_q[pick2];
    assign iss2_dst   = dst_q[pick2];

    // Allocation
    logic [DEPTH-1:0]         slot_hit;
    logic [DEPTH-1:0][PW-1:0] slot_port;
    logic                     enough;

    iq_alloc #(.DEPTH(DEPTH), .PORTS(PORTS)) u_alloc (
        .free(~valid_q), .slot_hit(slot_hit), .slot_port(slot_port), .enough(enough)
    );

    assign wr_accept = enough;

    // State update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            rdy0_q  <= '0;
            rdy1_q  <= '0;
            cls_q   <= '0;
            src0_q  <= '0;
            src1_q  <= '0;
            dst_q   <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                rdy0_q[i] <= rdy0_q[i] | wake0[i];
                rdy1_q[i] <= rdy1_q[i] | wake1[i];
                if ((found1 && (pick1 == IDX_W'(i))) || (found2 && (pick2 == IDX_W'(i)))) begin
                    valid_q[i] <= 1'b0;
                end
                if (slot_hit[i] && enough && in_valid[slot_port[i]]) begin
                    valid_q[i] <= 1'b1;
                    cls_q[i]   <= in_cls[slot_port[i]];
                    src0_q[i]  <= in_src0[slot_port[i]];
                    src1_q[i]  <= in_src1[slot_port[i]];
                    dst_q[i]   <= in_dst[slot_port[i]];
                    rdy0_q[i]  <= in_rdy0[slot_port[i]] | nwake0[slot_port[i]];
                    rdy1_q[i]  <= in_rdy1[slot_port[i]] | nwake1[slot_port[i]];
                end
            end
        end
    end

endmodule

// File: rtl/iq_checker.sv
module iq_checker
    import iq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             alu2_busy,
    input logic             iss1_valid,
    input logic             iss2_valid,
    input logic [CLS_W-1:0] iss1_cls,
    input logic [CLS_W-1:0] iss2_cls,
    input logic [IDX_W-1:0] pick1,
    input logic [IDX_W-1:0] pick2,
    input logic [DEPTH-1:0] valid_q
);

    AST_UNIT2_NO_BRANCH_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        iss2_valid |-> !unit1_only(iss2_cls));                     // R5

    AST_UNIT1_NO_MUL_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        iss1_valid |-> !unit2_only(iss1_cls));                     // R6

    AST_DISTINCT_PICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (iss1_valid && iss2_valid) |-> (pick1 != pick2));          // R7

    AST_BUSY_BLOCKS_UNIT2: assert property (@(posedge clk) disable iff (!rst_n)
        alu2_busy |-> !iss2_valid);                                // R8

    AST_ISSUE_FROM_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        iss1_valid |-> valid_q[pick1]);                            // R4

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));                                // R10

    AST_ISSUE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (iss1_valid && !flush) |=> !valid_q[$past(pick1)]);        // R11

endmodule

bind int_issue_queue iq_checker #(.DEPTH(DEPTH)) u_iq_checker (
    .clk(clk), .rst_n(rst_n), .flush(flush), .alu2_busy(alu2_busy),
    .iss1_valid(iss1_valid), .iss2_valid(iss2_valid),
    .iss1_cls(iss1_cls), .iss2_cls(iss2_cls),
    .pick1(pick1), .pick2(pick2), .valid_q(valid_q)
);

// File: tb/test_int_issue_queue.sv
module test_int_issue_queue;
    import iq_pkg::*;

    localparam int DEPTH = 16;
    localparam int PORTS = 4;
    localparam int TAG_W = 6;
    localparam int NBC   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic [PORTS-1:0]             in_valid = '0;
    logic [PORTS-1:0][CLS_W-1:0]  in_cls = '0;
    logic [PORTS-1:0][TAG_W-1:0]  in_src0 = '0;
    logic [PORTS-1:0]             in_rdy0 = '0;
    logic [PORTS-1:0][TAG_W-1:0]  in_src1 = '0;
    logic [PORTS-1:0]             in_rdy1 = '0;
    logic [PORTS-1:0][TAG_W-1:0]  in_dst = '0;
    logic                         wr_accept;
    logic [NBC-1:0]               bc_valid = '0;
    logic [NBC-1:0][TAG_W-1:0]    bc_tag = '0;
    logic                         alu2_busy = 1'b0;
    logic                         iss1_valid, iss2_valid;
    logic [CLS_W-1:0]             iss1_cls, iss2_cls;
    logic [TAG_W-1:0]             iss1_src0, iss1_src1, iss1_dst;
    logic [TAG_W-1:0]             iss2_src0, iss2_src1, iss2_dst;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    int_issue_queue #(.DEPTH(DEPTH), .PORTS(PORTS), .TAG_W(TAG_W), .NBC(NBC)) i_int_issue_queue (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .in_valid(in_valid), .in_cls(in_cls), .in_src0(in_src0), .in_rdy0(in_rdy0),
        .in_src1(in_src1), .in_rdy1(in_rdy1), .in_dst(in_dst), .wr_accept(wr_accept),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .alu2_busy(alu2_busy),
        .iss1_valid(iss1_valid), .iss1_cls(iss1_cls), .iss1_src0(iss1_src0),
        .iss1_src1(iss1_src1), .iss1_dst(iss1_dst),
        .iss2_valid(iss2_valid), .iss2_cls(iss2_cls), .iss2_src0(iss2_src0),
        .iss2_src1(iss2_src1), .iss2_dst(iss2_dst)
    );

    // Behavioural reference state
    bit m_v[DEPTH];
    bit m_r0[DEPTH];
    bit m_r1[DEPTH];
    int m_cls[DEPTH];
    int m_s0[DEPTH];
    int m_s1[DEPTH];
    int m_dst[DEPTH];
    bit e1v, e2v;
    int e1i, e2i;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    function automatic bit bcast_hit(int tag);
        for (int b = 0; b < NBC; b++) begin
            if (bc_valid[b] && (int'(bc_tag[b]) == tag)) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic int free_count();
        int n = 0;
        for (int i = 0; i < DEPTH; i++) if (!m_v[i]) n++;
        return n;
    endfunction

    function automatic void predict();
        e1v = 0; e2v = 0; e1i = 0; e2i = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!e1v && m_v[i] && m_r0[i] && m_r1[i] && m_cls[i] != 3 && m_cls[i] != 4) begin
                e1v = 1; e1i = i;
            end
        end
        if (!alu2_busy) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!e2v && m_v[i] && m_r0[i] && m_r1[i] && m_cls[i] != 1 && m_cls[i] != 2
                    && !(e1v && e1i == i)) begin
                    e2v = 1; e2i = i;
                end
            end
        end
    endfunction

    function automatic void model_edge();
        int slots[$];
        bit acc;
        if (!rst_n || flush) begin
            for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
            return;
        end
        for (int i = 0; i < DEPTH; i++) if (!m_v[i] && slots.size() < PORTS) slots.push_back(i);
        acc = (free_count() >= PORTS);
        for (int i = 0; i < DEPTH; i++) begin
            if (bcast_hit(m_s0[i])) m_r0[i] = 1;
            if (bcast_hit(m_s1[i])) m_r1[i] = 1;
        end
        if (e1v) m_v[e1i] = 0;
        if (e2v) m_v[e2i] = 0;
        if (acc) begin
            for (int k = 0; k < PORTS; k++) begin
                if (in_valid[k]) begin
                    int s = slots[k];
                    m_v[s]   = 1;
                    m_cls[s] = int'(in_cls[k]);
                    m_s0[s]  = int'(in_src0[k]);
                    m_s1[s]  = int'(in_src1[k]);
                    m_dst[s] = int'(in_dst[k]);
                    m_r0[s]  = in_rdy0[k] | bcast_hit(int'(in_src0[k]));
                    m_r1[s]  = in_rdy1[k] | bcast_hit(int'(in_src1[k]));
                end
            end
        end
    endfunction

    // One clock: compare away from the edge, then advance the model at the edge
    task automatic cycle();
        int exp_acc;
        #1;
        predict();
        exp_acc = (free_count() >= PORTS) ? 1 : 0;
        if (rst_n) begin
            chk(int'(wr_accept) == exp_acc, "R3 wr_accept", int'(wr_accept), exp_acc);
            chk(iss1_valid == e1v, "R4 iss1_valid", int'(iss1_valid), int'(e1v));
            chk(iss2_valid == e2v, "R7 iss2_valid", int'(iss2_valid), int'(e2v));
            if (e1v && iss1_valid) begin
                chk(int'(iss1_cls) == m_cls[e1i], "R6 iss1_cls", int'(iss1_cls), m_cls[e1i]);
                chk(int'(iss1_dst) == m_dst[e1i], "R2 iss1_dst", int'(iss1_dst), m_dst[e1i]);
                chk(int'(iss1_src0) == m_s0[e1i] && int'(iss1_src1) == m_s1[e1i],
                    "R2 iss1_src", int'(iss1_src0), m_s0[e1i]);
            end
            if (e2v && iss2_valid) begin
                chk(int'(iss2_cls) == m_cls[e2i], "R5 iss2_cls", int'(iss2_cls), m_cls[e2i]);
                chk(int'(iss2_dst) == m_dst[e2i], "R2 iss2_dst", int'(iss2_dst), m_dst[e2i]);
                chk(int'(iss2_src0) == m_s0[e2i] && int'(iss2_src1) == m_s1[e2i],
                    "R2 iss2_src", int'(iss2_src0), m_s0[e2i]);
            end
            if (alu2_busy) chk(!iss2_valid, "R8 busy blocks unit 2", int'(iss2_valid), 0);
        end
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        in_valid = '0; bc_valid = '0; flush = 1'b0; alu2_busy = 1'b0;
    endtask

    task automatic rand_inputs(int p_wr, int p_rdy, int p_bc, int p_busy, int p_flush);
        for (int k = 0; k < PORTS; k++) begin
            in_valid[k] = ($urandom_range(0, 99) < p_wr);
            in_cls[k]   = CLS_W'($urandom_range(0, 7));
            in_src0[k]  = TAG_W'($urandom_range(0, 7));
            in_src1[k]  = TAG_W'($urandom_range(0, 7));
            in_rdy0[k]  = ($urandom_range(0, 99) < p_rdy);
            in_rdy1[k]  = ($urandom_range(0, 99) < p_rdy);
            in_dst[k]   = TAG_W'($urandom_range(0, 63));
        end
        for (int b = 0; b < NBC; b++) begin
            bc_valid[b] = ($urandom_range(0, 99) < p_bc);
            bc_tag[b]   = TAG_W'($urandom_range(0, 7));
        end
        alu2_busy = ($urandom_range(0, 99) < p_busy);
        flush     = ($urandom_range(0, 99) < p_flush);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            #1;
            chk(!iss1_valid && !iss2_valid, "R1 no issue in reset", int'(iss1_valid | iss2_valid), 0);
            chk(wr_accept == 1'b1, "R1 accept in reset", int'(wr_accept), 1);
        end
        @(posedge clk);
        model_edge();
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(wr_accept == 1'b1, "R1 accept after reset", int'(wr_accept), 1);
        chk(!iss1_valid && !iss2_valid, "R1 empty after reset", int'(iss1_valid | iss2_valid), 0);

        // R2 R3: fill with waiting instructions, then offer more while full
        for (int c = 0; c < 5; c++) begin
            for (int k = 0; k < PORTS; k++) begin
                in_valid[k] = 1'b1;
                in_cls[k]   = CLS_W'((c * 4 + k) % 8);
                in_src0[k]  = TAG_W'(16 + c * 4 + k);
                in_rdy0[k]  = 1'b0;
                in_src1[k]  = TAG_W'(k);
                in_rdy1[k]  = 1'b1;
                in_dst[k]   = TAG_W'(c * 4 + k);
            end
            cycle();
        end
        #1;
        chk(wr_accept == 1'b0, "R3 full queue refuses", int'(wr_accept), 0);
        in_valid = '0;

        // R9 R8: wake pairs, with unit 2 busy for the first half
        for (int t = 16; t < 32; t += 2) begin
            bc_valid  = 2'b11;
            bc_tag[0] = TAG_W'(t);
            bc_tag[1] = TAG_W'(t + 1);
            alu2_busy = (t < 24);
            cycle();
        end
        idle_inputs();
        repeat (12) cycle();

        // R10: flush with writes offered in the same cycle
        rand_inputs(100, 100, 0, 0, 0);
        cycle();
        in_valid = '1;
        flush = 1'b1;
        cycle();
        idle_inputs();
        #1;
        chk(!iss1_valid && !iss2_valid, "R10 empty after flush", int'(iss1_valid | iss2_valid), 0);
        chk(wr_accept == 1'b1, "R10 accept after flush", int'(wr_accept), 1);

        // R9 R11: wake in the write cycle, issue once, then nothing
        in_valid = 4'b0001;
        in_cls[0] = CLS_W'(CLS_MUL);
        in_src0[0] = TAG_W'(50); in_rdy0[0] = 1'b0;
        in_src1[0] = TAG_W'(51); in_rdy1[0] = 1'b1;
        in_dst[0] = TAG_W'(9);
        bc_valid = 2'b10; bc_tag[1] = TAG_W'(50);
        cycle();
        idle_inputs();
        #1;
        chk(iss2_valid && int'(iss2_dst) == 9, "R9 same-cycle wake issues", int'(iss2_valid), 1);
        chk(!iss1_valid, "R6 multiply stays off unit 1", int'(iss1_valid), 0);
        cycle();
        #1;
        chk(!iss2_valid && !iss1_valid, "R11 released after issue", int'(iss2_valid), 0);

        // Random phases with differing pressure
        for (int n = 0; n < 3000; n++) begin rand_inputs(60, 30, 60, 20, 1); cycle(); end
        for (int n = 0; n < 3000; n++) begin rand_inputs(90, 10, 30, 50, 0); cycle(); end
        for (int n = 0; n < 3000; n++) begin rand_inputs(40, 80, 80, 0, 2); cycle(); end
        idle_inputs();
        repeat (20) cycle();

        finish_run();
    end

endmodule